// File: doc/BRIEF.md
# Burst Column Address Generator

This block turns one column command into the stream of column addresses that a synchronous DRAM burst visits. When a start strobe is sampled it captures the starting column and the burst settings from the mode word. From the next clock on it presents one column address per cycle with a valid flag. It raises a last flag on the final beat of a finite burst.

Finite bursts of 2, 4 or 8 stay inside the aligned group of that many columns and wrap at its edge. The visiting order is either sequential (count upward and wrap) or interleaved (start offset XOR beat number). A page-length burst walks the whole column space sequentially and wraps round forever until a terminate strobe stops it.

A write-single mode bit turns write bursts into single-location accesses while reads keep the programmed length. Reserved length codes, and an interleaved page burst, raise an error flag and run as a single beat.

Top module: `burst_col_gen`

## Requirements
- R1: While reset is high, and in the cycle after reset is released with no start, col_valid_o, col_last_o and cfg_err_o are low.
- R2: A start strobe sampled on a clock edge makes col_valid_o high in the following cycle, with col_o equal to the starting column. One address is then presented per clock.
- R3: Mode bits [2:0] select the length: 000 gives 1 beat, 001 gives 2, 010 gives 4 and 011 gives 8. col_last_o is high only on the final beat. col_valid_o falls after the final beat unless a new start arrives.
- R4: With mode bit 3 = 0 (sequential), beat k addresses column base + ((off + k) mod L). Here off is the start column mod L and base is the start column with its low log2(L) bits cleared.
- R5: With mode bit 3 = 1 (interleaved), beat k addresses base + (off XOR k). For example, start 5 at length 8 gives 5,4,7,6,1,0,3,2.
- R6: Code 111 gives a page burst. It is sequential over all 2^COL_W columns, wraps from the top column to 0, never raises col_last_o, and runs until terminated.
- R7: For length code 000, the burst type bit has no effect on the address.
- R8: When mode bit 9 = 1, a burst started with wr_i = 1 is a single beat. A burst started with wr_i = 0 keeps the programmed length. When mode bit 9 = 0, writes keep the programmed length.
- R9: Length codes 100, 101 and 110, and code 111 together with mode bit 3 = 1, set cfg_err_o from the cycle after start until the next start, and run as a single beat.
- R10: A terminate strobe sampled during a burst makes col_valid_o low in the next cycle. A terminate strobe while idle has no effect.
- R11: A start strobe during a running burst restarts the sequence from the new starting column with the new settings. Start wins over a simultaneous terminate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a burst at col_i with mode_i settings |
| term_i | input | 1 | Stop the running burst |
| wr_i | input | 1 | The burst being started is a write |
| col_i | input | COL_W | Starting column |
| mode_i | input | 10 | Mode word: [2:0] length code, [3] type, [9] write-single |
| col_valid_o | output | 1 | col_o carries a burst address this cycle |
| col_o | output | COL_W | Current column address |
| col_last_o | output | 1 | Final beat of a finite burst |
| cfg_err_o | output | 1 | Settings of the current/last burst were invalid |

## Verification
The bench builds the block with the default 8-bit column, so a 256-column page is short enough to drive past its wrap point in one run. That width also brings the top-column-to-zero rollover of the page burst within reach, alongside every block alignment for lengths 2, 4 and 8. A reference model written with plain integers predicts valid, address, last and error on every clock. Stimulus covers each length and type, block-edge starts, write-single, reserved codes, and terminate and restart both mid-burst and while idle.

// File: rtl/bcg_pkg.sv
package bcg_pkg;

    localparam int MODE_W  = 10;
    localparam int BT_BIT  = 3;
    localparam int WBS_BIT = 9;

    typedef enum logic [2:0] {
        LEN_ONE   = 3'b000,
        LEN_TWO   = 3'b001,
        LEN_FOUR  = 3'b010,
        LEN_EIGHT = 3'b011,
        LEN_PAGE  = 3'b111
    } len_code_e;

    typedef struct packed {
        logic       page;
        logic       ilv;
        logic       err;
        logic [1:0] len_log2;
    } burst_cfg_t;

    function automatic burst_cfg_t decode_len(input logic [2:0] code, input logic ilv);
        burst_cfg_t c;
        c.page     = 1'b0;
        c.ilv      = ilv;
        c.err      = 1'b0;
        c.len_log2 = 2'd0;
        case (code)
            LEN_ONE:   c.len_log2 = 2'd0;
            LEN_TWO:   c.len_log2 = 2'd1;
            LEN_FOUR:  c.len_log2 = 2'd2;
            LEN_EIGHT: c.len_log2 = 2'd3;
            LEN_PAGE:  c.page     = 1'b1;
            default:   c.err      = 1'b1;
        endcase
        if (c.page && ilv) c.err = 1'b1;
        if (c.err) begin
            c.page     = 1'b0;
            c.len_log2 = 2'd0;
        end
        return c;
    endfunction

endpackage

// File: rtl/bcg_mode_decode.sv
module bcg_mode_decode
    import bcg_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic [MODE_W-1:0] mode_i,
    input  logic              wr_i,
    output burst_cfg_t        cfg_o,
    output logic [COL_W-1:0]  mask_o
);
    burst_cfg_t raw;

    always_comb begin
        raw   = decode_len(mode_i[2:0], mode_i[BT_BIT]);
        cfg_o = raw;
        if (wr_i && mode_i[WBS_BIT]) begin
            cfg_o.page     = 1'b0;
            cfg_o.len_log2 = 2'd0;
        end
    end

    for (genvar i = 0; i < COL_W; i++) begin : g_mask
        assign mask_o[i] = cfg_o.page || (i < int'(cfg_o.len_log2));
    end

endmodule

// File: rtl/bcg_col_calc.sv
module bcg_col_calc #(
    parameter int COL_W = 8
) (
    input  logic [COL_W-1:0] base_i,
    input  logic [COL_W-1:0] beat_i,
    input  logic [COL_W-1:0] mask_i,
    input  logic             ilv_i,
    output logic [COL_W-1:0] col_o
);
    logic [COL_W-1:0] walk;

    always_comb begin
        walk  = ilv_i ? (base_i ^ beat_i) : (base_i + beat_i);
        col_o = (base_i & ~mask_i) | (walk & mask_i);
    end

endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
    import bcg_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              term_i,
    input  logic              wr_i,
    input  logic [COL_W-1:0]  col_i,
    input  logic [MODE_W-1:0] mode_i,
    output logic              col_valid_o,
    output logic [COL_W-1:0]  col_o,
    output logic              col_last_o,
    output logic              cfg_err_o
);
    burst_cfg_t       cfg_d;
    logic [COL_W-1:0] mask_d;

    logic             act_q;
    logic [COL_W-1:0] base_q;
    logic [COL_W-1:0] beat_q;
    logic [COL_W-1:0] mask_q;
    logic             ilv_q;
    logic             page_q;
    logic             err_q;
    logic             at_end;

    bcg_mode_decode #(.COL_W(COL_W)) i_dec (
        .mode_i (mode_i),
        .wr_i   (wr_i),
        .cfg_o  (cfg_d),
        .mask_o (mask_d)
    );

    bcg_col_calc #(.COL_W(COL_W)) i_calc (
        .base_i (base_q),
        .beat_i (beat_q),
        .mask_i (mask_q),
        .ilv_i  (ilv_q),
        .col_o  (col_o)
    );

    assign at_end = !page_q && (beat_q == mask_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q  <= 1'b0;
            base_q <= '0;
            beat_q <= '0;
            mask_q <= '0;
            ilv_q  <= 1'b0;
            page_q <= 1'b0;
            err_q  <= 1'b0;
        end else if (start_i) begin
            act_q  <= 1'b1;
            base_q <= col_i;
            beat_q <= '0;
            mask_q <= mask_d;
            ilv_q  <= cfg_d.ilv;
            page_q <= cfg_d.page;
            err_q  <= cfg_d.err;
        end else if (act_q) begin
            if (term_i || at_end) act_q <= 1'b0;
            else                  beat_q <= beat_q + 1'b1;
        end
    end

    assign col_valid_o = act_q;
    assign col_last_o  = act_q && at_end;
    assign cfg_err_o   = err_q;

    assert_start_loads_R2: assert property (@(posedge clk) disable iff (rst)
        start_i |=> (col_valid_o && col_o == $past(col_i)));

    assert_last_in_burst_R3: assert property (@(posedge clk) disable iff (rst)
        col_last_o |-> col_valid_o);

    assert_end_after_last_R3: assert property (@(posedge clk) disable iff (rst)
        (col_last_o && !start_i) |=> !col_valid_o);

    assert_page_steps_R6: assert property (@(posedge clk) disable iff (rst)
        (col_valid_o && page_q && !start_i && !term_i) |=>
            (col_valid_o && col_o == COL_W'($past(col_o) + 1'b1)));

    assert_err_single_R9: assert property (@(posedge clk) disable iff (rst)
        (cfg_err_o && col_valid_o) |-> col_last_o);

    assert_term_stops_R10: assert property (@(posedge clk) disable iff (rst)
        (term_i && !start_i) |=> !col_valid_o);

endmodule

// File: tb/test_burst_col_gen.sv
module test_burst_col_gen;
    localparam int COL_W = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start_i = 1'b0;
    logic             term_i = 1'b0;
    logic             wr_i = 1'b0;
    logic [COL_W-1:0] col_i = '0;
    logic [9:0]       mode_i = '0;
    logic             col_valid_o;
    logic [COL_W-1:0] col_o;
    logic             col_last_o;
    logic             cfg_err_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    string cur_req = "R1";

    always #10 clk = ~clk;

    burst_col_gen #(.COL_W(COL_W)) i_burst_col_gen (
        .clk(clk), .rst(rst), .start_i(start_i), .term_i(term_i), .wr_i(wr_i),
        .col_i(col_i), .mode_i(mode_i), .col_valid_o(col_valid_o), .col_o(col_o),
        .col_last_o(col_last_o), .cfg_err_o(cfg_err_o)
    );

    // behavioural reference: len 0 means page burst
    int m_act = 0, m_beat = 0, m_len = 1, m_start = 0, m_ilv = 0, m_err = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_act = 0; m_err = 0; m_beat = 0;
        end else if (start_i) begin
            int code;
            code = int'(mode_i[2:0]);
            m_err = 0;
            case (code)
                0: m_len = 1;
                1: m_len = 2;
                2: m_len = 4;
                3: m_len = 8;
                7: m_len = 0;
                default: m_err = 1;
            endcase
            if (code == 7 && mode_i[3]) m_err = 1;
            if (m_err) m_len = 1;
            if (wr_i && mode_i[9]) m_len = 1;
            m_ilv = int'(mode_i[3]);
            m_start = int'(col_i);
            m_beat = 0;
            m_act = 1;
        end else if (m_act) begin
            if (term_i) m_act = 0;
            else if (m_len != 0 && m_beat == m_len - 1) m_act = 0;
            else m_beat++;
        end
    end

    function automatic int exp_addr();
        int blk, off, idx;
        blk = (m_len == 0) ? (1 << COL_W) : m_len;
        off = m_start % blk;
        idx = m_ilv ? (off ^ m_beat) : ((off + m_beat) % blk);
        return m_start - off + idx;
    endfunction

    task automatic chk(input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", cur_req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        cycles++;
        if (!rst) begin
            int e_last;
            e_last = (m_act && m_len != 0 && m_beat == m_len - 1) ? 1 : 0;
            chk("valid", int'(col_valid_o), m_act);
            chk("last", int'(col_last_o), e_last);
            chk("err", int'(cfg_err_o), m_err);
            if (m_act) chk("col", int'(col_o), exp_addr());
        end
        if (cycles > 200000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    function automatic logic [9:0] mk(input int code, input int bt, input int wbs);
        logic [9:0] m;
        m = '0;
        m[2:0] = 3'(code);
        m[3] = 1'(bt);
        m[9] = 1'(wbs);
        return m;
    endfunction

    task automatic go(input string req, input int col, input logic [9:0] mode, input int wr, input int hold);
        @(negedge clk);
        cur_req = req;
        start_i = 1'b1;
        col_i = COL_W'(col);
        mode_i = mode;
        wr_i = 1'(wr);
        @(negedge clk);
        start_i = 1'b0;
        repeat (hold) @(negedge clk);
    endtask

    task automatic pulse_term(input string req);
        @(negedge clk);
        cur_req = req;
        term_i = 1'b1;
        @(negedge clk);
        term_i = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        cur_req = "R1";
        chk("reset valid", int'(col_valid_o), 0);
        chk("reset last", int'(col_last_o), 0);
        chk("reset err", int'(cfg_err_o), 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        // R2/R3 every length, sequential
        go("R2/R3", 16'h10, mk(0, 0, 0), 0, 3);
        go("R2/R3", 16'h10, mk(1, 0, 0), 0, 3);
        go("R2/R3", 16'h11, mk(1, 0, 0), 0, 3);
        go("R2/R3", 16'h10, mk(2, 0, 0), 0, 5);
        go("R2/R3", 16'h10, mk(3, 0, 0), 0, 9);
        // R4 wrap inside aligned block
        go("R4", 16'h2E, mk(3, 0, 0), 0, 9);
        go("R4", 16'h47, mk(2, 0, 0), 0, 5);
        go("R4", 16'hFF, mk(3, 0, 0), 0, 9);
        // R5 interleaved
        go("R5", 16'h05, mk(3, 1, 0), 0, 9);
        go("R5", 16'h12, mk(2, 1, 0), 0, 5);
        go("R5", 16'h33, mk(1, 1, 0), 0, 3);
        go("R5", 16'hBE, mk(3, 1, 0), 0, 9);
        // R7 type ignored at length one
        go("R7", 16'h9A, mk(0, 1, 0), 0, 3);
        // R6 page burst crosses top column
        go("R6", 16'hF0, mk(7, 0, 0), 0, 300);
        pulse_term("R6/R10");
        repeat (3) @(negedge clk);
        // R10 terminate mid burst and while idle
        go("R10", 16'h40, mk(3, 0, 0), 0, 2);
        pulse_term("R10");
        repeat (3) @(negedge clk);
        pulse_term("R10");
        repeat (3) @(negedge clk);
        // R11 restart mid burst, start wins over terminate
        go("R11", 16'h20, mk(3, 0, 0), 0, 2);
        go("R11", 16'h83, mk(2, 1, 0), 0, 1);
        @(negedge clk);
        cur_req = "R11";
        start_i = 1'b1; term_i = 1'b1; col_i = 8'h6C; mode_i = mk(2, 0, 0);
        @(negedge clk);
        start_i = 1'b0; term_i = 1'b0;
        repeat (6) @(negedge clk);
        go("R11", 16'h01, mk(1, 0, 0), 0, 0);
        go("R11", 16'h09, mk(1, 1, 0), 0, 4);
        // R8 write-single
        go("R8", 16'h55, mk(3, 0, 1), 1, 9);
        go("R8", 16'h55, mk(3, 0, 1), 0, 9);
        go("R8", 16'h55, mk(3, 0, 0), 1, 9);
        go("R8", 16'h70, mk(7, 0, 1), 1, 4);
        // R9 reserved codes and interleaved page
        go("R9", 16'h31, mk(4, 0, 0), 0, 3);
        go("R9", 16'h32, mk(5, 1, 0), 0, 3);
        go("R9", 16'h33, mk(6, 0, 0), 0, 3);
        go("R9", 16'h34, mk(7, 1, 0), 0, 4);
        go("R9", 16'h35, mk(2, 0, 0), 0, 5);
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule